// File: doc/BRIEF.md
# Address and Occupancy Controller for an SRAM-Backed FIFO

This block runs a first-in first-out queue whose words are stored in a separate SRAM. The block keeps no data itself. It holds a tail pointer, which marks where the next word is enqueued, and a head pointer, which marks where the oldest word is dequeued. It also keeps a count of the words held. The SRAM has only one address bus, so each cycle allows at most one access. The block picks that access and places the matching pointer on the bus. Data moves directly between the user and the SRAM and does not pass through the block.

A user raises `push_req` to enqueue and `pop_req` to dequeue. When a request is accepted, the block drives `mem_wr_en` or `mem_rd_en` for the same cycle, with `mem_addr` combinationally valid. The pointer and the count advance at the following rising edge. Three status outputs report the fill level: queue full, queue empty, and at least half full. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `q_half`=0, and both pointers are 0. The first accepted write therefore uses address 0, and so does the first accepted read.
- R2: An accepted enqueue drives `mem_wr_en`=1 and `mem_rd_en`=0, with `mem_addr` equal to the tail pointer. The tail pointer then advances by one.
- R3: An accepted dequeue drives `mem_rd_en`=1 and `mem_wr_en`=0, with `mem_addr` equal to the head pointer. The head pointer then advances by one.
- R4: If both requests are raised and the queue is not empty, the dequeue is accepted and the enqueue is dropped for that cycle.
- R5: If both requests are raised while the queue is empty, the enqueue is accepted.
- R6: An enqueue request while `q_full`=1 drives no write and leaves the pointers and the count unchanged.
- R7: A dequeue request while `q_empty`=1 drives no read and leaves the pointers and the count unchanged.
- R8: Dequeue addresses appear in exactly the order of the enqueue addresses.
- R9: Each pointer wraps from 32767 to 0.
- R10: The count ranges from 0 to 32768. `q_full` is set when the count is 32768, `q_empty` when it is 0, and `q_half` when it is 16384 or more.
- R11: `mem_wr_en` and `mem_rd_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Enqueue request |
| pop_req | input | 1 | Dequeue request |
| mem_addr | output | 15 | SRAM address: tail pointer on a write, head pointer otherwise |
| mem_wr_en | output | 1 | Active-high SRAM write strobe for an accepted enqueue |
| mem_rd_en | output | 1 | Active-high SRAM output enable for an accepted dequeue |
| q_full | output | 1 | Count equals 32768 |
| q_empty | output | 1 | Count equals 0 |
| q_half | output | 1 | Count is 16384 or more |

## Verification
The first pattern is short alternating bursts of enqueues and dequeues. It separates correct head and tail selection on the bus from a swapped selection. Simultaneous requests are driven both when the queue is empty and when it is not, which shows whether read priority yields correctly to an empty queue. A full fill, started from a non-zero pointer position, forces the tail pointer to wrap. It also passes the half and full thresholds at exactly one count apart, and over-requests at full and at empty show that rejected operations leave the state untouched. A full drain is then compared address by address against a scoreboard queue, which checks ordering across the wrap.

// File: rtl/sram_fifo_ctrl_pkg.sv
package sram_fifo_ctrl_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_POP  = 2'd1,
    OP_PUSH = 2'd2
  } fifo_op_e;
endpackage

// File: rtl/fifo_op_select.sv
module fifo_op_select
  import sram_fifo_ctrl_pkg::*;
(
  input  logic     push_req,
  input  logic     pop_req,
  input  logic     is_full,
  input  logic     is_empty,
  output fifo_op_e op
);
  // Dequeue wins when it can proceed; otherwise a legal enqueue goes ahead.
  always_comb begin
    op = OP_NONE;
    if (pop_req && !is_empty)      op = OP_POP;
    else if (push_req && !is_full) op = OP_PUSH;
  end
endmodule

// File: rtl/fifo_wrap_ptr.sv
module fifo_wrap_ptr #(
  parameter int PTR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;

  // Natural modulo-2^PTR_W overflow gives the wrap to zero.
  always_comb begin
    ptr_d = ptr;
    if (step) ptr_d = ptr + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/fifo_occupancy.sv
module fifo_occupancy #(
  parameter int ADDR_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          down,
  output logic [ADDR_W:0] level,
  output logic          is_full,
  output logic          is_empty,
  output logic          is_half
);
  localparam logic [ADDR_W:0] CAP  = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF = CAP >> 1;

  logic [ADDR_W:0] level_d;

  always_comb begin
    level_d = level;
    if (up && !down)      level_d = level + (ADDR_W+1)'(1);
    else if (down && !up) level_d = level - (ADDR_W+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_d;
  end

  assign is_full  = (level == CAP);
  assign is_empty = (level == '0);
  assign is_half  = (level >= HALF);
endmodule

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl
  import sram_fifo_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic              q_full,
  output logic              q_empty,
  output logic              q_half
);
  localparam int N_PTR = 2;
  localparam int HEAD  = 0;
  localparam int TAIL  = 1;

  // Reset: asserted asynchronously, released on the second rising edge.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  fifo_op_e          op;
  logic [N_PTR-1:0]  ptr_step;
  logic [ADDR_W-1:0] ptr_val [N_PTR];
  logic [ADDR_W:0]   level;

  fifo_op_select u_sel (
    .push_req (push_req),
    .pop_req  (pop_req),
    .is_full  (q_full),
    .is_empty (q_empty),
    .op       (op)
  );

  assign ptr_step[HEAD] = (op == OP_POP);
  assign ptr_step[TAIL] = (op == OP_PUSH);

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    fifo_wrap_ptr #(.PTR_W(ADDR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_ni),
      .step  (ptr_step[g]),
      .ptr   (ptr_val[g])
    );
  end

  fifo_occupancy #(.ADDR_W(ADDR_W)) u_occ (
    .clk      (clk),
    .rst_n    (rst_ni),
    .up       (ptr_step[TAIL]),
    .down     (ptr_step[HEAD]),
    .level    (level),
    .is_full  (q_full),
    .is_empty (q_empty),
    .is_half  (q_half)
  );

  // Single address bus: tail pointer on a write, head pointer otherwise.
  assign mem_addr  = (op == OP_PUSH) ? ptr_val[TAIL] : ptr_val[HEAD];
  assign mem_wr_en = ptr_step[TAIL];
  assign mem_rd_en = ptr_step[HEAD];
endmodule

// File: rtl/sram_fifo_ctrl_chk.sv
module sram_fifo_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              push_req,
  input logic              pop_req,
  input logic              mem_wr_en,
  input logic              mem_rd_en,
  input logic              q_full,
  input logic              q_empty,
  input logic              q_half,
  input logic [ADDR_W:0]   level
);
  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(mem_wr_en && mem_rd_en));

  // R6
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (q_full && push_req) |-> !mem_wr_en);

  // R7
  no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    q_empty |-> !mem_rd_en);

  // R4
  read_priority_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_req && push_req && !q_empty) |-> (mem_rd_en && !mem_wr_en));

  // R5
  empty_both_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_req && push_req && q_empty) |-> mem_wr_en);

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mem_wr_en && !mem_rd_en) |=> $stable(level));

  // R10
  flag_order_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    q_full |-> (q_half && !q_empty));
endmodule

bind sram_fifo_ctrl sram_fifo_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .mem_wr_en (mem_wr_en),
  .mem_rd_en (mem_rd_en),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .q_half    (q_half),
  .level     (level)
);

// File: tb/sram_fifo_ctrl_test.sv
module sram_fifo_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 15;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0;
  logic pop_req = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_wr_en, mem_rd_en, q_full, q_empty, q_half;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int m_tail = 0;
  int m_level = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_fifo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .q_full(q_full), .q_empty(q_empty), .q_half(q_half)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check({req, " full"},  q_full,  m_level == DEPTH);
    check({req, " empty"}, q_empty, m_level == 0);
    check({req, " half"},  q_half,  m_level >= DEPTH/2);
  endtask

  // Driver: one cycle of requests; expected enqueue addresses go to the scoreboard.
  task automatic drive(input bit rd, input bit wr, input string req);
    bit rd_ok, wr_ok;
    @(negedge clk);
    pop_req = rd; push_req = wr;
    rd_ok = rd && (m_level != 0);
    wr_ok = !rd_ok && wr && (m_level != DEPTH);
    #1;
    check({req, " rd_en"}, mem_rd_en, rd_ok);
    check({req, " wr_en"}, mem_wr_en, wr_ok);
    if (wr_ok) begin
      check({req, " R2 wr addr"}, mem_addr, m_tail);
      exp_q.push_back(m_tail);
      m_tail = (m_tail + 1) % DEPTH;
      m_level++;
    end
    if (rd_ok) m_level--;
  endtask

  task automatic idle();
    @(negedge clk);
    pop_req = 0; push_req = 0;
    #1;
  endtask

  // Monitor: every dequeue address must match the oldest enqueue (R3, R8).
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_rd_en) begin
      if (exp_q.size() == 0) check("R8 pop without push", 1, 0);
      else check("R3/R8 rd addr", mem_addr, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check_flags("R1 reset");
    check("R1 reset wr_en", mem_wr_en, 0);

    // R1, R2: first write lands at 0; short bursts.
    for (int i = 0; i < 3; i++) drive(0, 1, "R2 burst");
    idle(); check_flags("R10 after 3");
    for (int i = 0; i < 2; i++) drive(1, 0, "R3 burst");
    // R4: both requested with data present -> read wins.
    drive(1, 1, "R4 both");
    idle(); check_flags("R4 drained");
    // R7: read while empty ignored.
    drive(1, 0, "R7 rd empty");
    idle(); check_flags("R7 state kept");
    // R5: both while empty -> write.
    drive(1, 1, "R5 both empty");
    drive(0, 1, "R2 one more");
    drive(1, 0, "R3 rd");
    drive(1, 0, "R3 rd");
    idle(); check_flags("R5 back to empty");

    // Fill completely; tail (now 5) wraps past 32767 (R9, R10).
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 1, "R9 fill");
      if (m_level == DEPTH/2 - 1 || m_level == DEPTH/2 ||
          m_level == DEPTH - 1) begin
        idle(); check_flags("R10 threshold");
      end
    end
    idle(); check_flags("R10 full");
    // R6: writes while full ignored.
    drive(0, 1, "R6 wr full");
    drive(0, 1, "R6 wr full");
    idle(); check_flags("R6 state kept");
    // Drain fully; monitor checks order across the wrap (R8).
    for (int i = 0; i < DEPTH; i++) drive(1, 0, "R8 drain");
    idle(); check_flags("R10 empty again");
    check("R8 scoreboard empty", exp_q.size(), 0);
    drive(0, 1, "R9 tail continues");
    idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule